// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This controller decides which clock domains of a processor subsystem receive clock in each of three power states: Run, Wait and Stop. Sleep requests come from the core when it executes its wait or stop instruction. Each request can be refused by a disable made of two flops. One flop is a one-time lock that only power-on reset clears. The other is a bit that software may rewrite at any time and that ordinary resets clear.

Each sleep state has its own small set of exit events. Wait ends on any unmasked pending interrupt. Stop ends only on a CAN-bus activity wake or an asynchronous interrupt, or on a reset. Both of those wake inputs come through a two-flop synchronizer. When Stop ends because of CAN activity, the controller pulses a flag so that the CAN receiver discards the first frame. The watchdog domain keeps its clock in every state.

The controller also keeps the PLL power-down request honest. The PLL can be off only while the system clock is taken from the oscillator, and entering Stop never turns the PLL off by itself. There is no data stream in this block, so every pin is a plain control or status level. None of them uses a valid/ready handshake.

Top module: `lpm_clkgate_ctrl`

## Requirements
- R1: In Run (mode code 0), core_clk_en, mem_clk_en and periph_clk_en are all 1. This is also the state directly after power-on reset, with pll_pd = 0 and can_drop_frame = 0.
- R2: A wait_req pulse in Run, when wait is not disabled, gives mode code 1 (Wait) from the next clock edge. In Wait, core_clk_en and mem_clk_en are 0 and periph_clk_en is 1.
- R3: In Wait, irq_pending = 1 returns the mode to Run at the next edge. A held async_irq returns it to Run after the synchronizer (third edge). A held can_wake has no effect in Wait and produces no drop pulse.
- R4: A stop_req pulse in Run, when stop is not disabled, gives mode code 2 (Stop) from the next edge. In Stop, core_clk_en, mem_clk_en and periph_clk_en are all 0.
- R5: Stop ends only on a synchronized can_wake or async_irq. A level that goes high between edges gives Run after the third following edge and not earlier. irq_pending never ends Stop.
- R6: Leaving Stop because of can_wake makes can_drop_frame 1 for exactly the first Run cycle. Leaving Stop on async_irq alone leaves can_drop_frame at 0.
- R7: A write with cfg_we = 1 loads the reprogrammable disables from the data bits: cfg_wdata bit 0 for stop and bit 1 for wait. The disable takes effect from the next edge. ext_rst_n = 0 or wdog_rst = 1 clears both reprogrammable disables.
- R8: The first cfg_we write after power-on reset fixes the permanent disables from the data bits: cfg_wdata bit 2 for stop and bit 3 for wait. Later writes leave them unchanged, and so do ext_rst_n and wdog_rst. Only por_n = 0 clears them.
- R9: A request whose disable is set (permanent or reprogrammable) leaves the mode in Run. When stop_req and wait_req arrive together, an allowed stop wins. A blocked stop falls through to an allowed wait.
- R10: pll_pd equals (pll_pd_req AND clk_sel_osc) as sampled at the previous edge. Entering Stop does not change it.
- R11: wdog_clk_en is 1 in every mode, including Stop.
- R12: ext_rst_n = 0 or wdog_rst = 1 puts the mode in Run, with Run clocks, at the next edge from any mode. por_n = 0 does the same at once, without waiting for an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears everything |
| ext_rst_n | input | 1 | External reset, sampled, active low |
| wdog_rst | input | 1 | Watchdog reset request, sampled, active high |
| wait_req | input | 1 | One-cycle pulse from the wait instruction |
| stop_req | input | 1 | One-cycle pulse from the stop instruction |
| irq_pending | input | 1 | Clocked unmasked interrupt pending level |
| async_irq | input | 1 | Non-clocked interrupt level, asynchronous |
| can_wake | input | 1 | CAN bus activity wake level, asynchronous |
| cfg_we | input | 1 | Disable configuration write strobe |
| cfg_wdata | input | 4 | Write data: [0] stop reprog, [1] wait reprog, [2] stop lock, [3] wait lock |
| clk_sel_osc | input | 1 | System clock select currently points at oscillator |
| pll_pd_req | input | 1 | Requested PLL power-down level |
| mode | output | 2 | Power state: 0 Run, 1 Wait, 2 Stop |
| core_clk_en | output | 1 | Core clock enable |
| mem_clk_en | output | 1 | Memory clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| wdog_clk_en | output | 1 | Watchdog clock enable |
| pll_pd | output | 1 | PLL power-down control |
| can_drop_frame | output | 1 | One-cycle pulse telling the CAN receiver to drop a frame |

## Verification
The bench holds can_wake and irq_pending through Wait and through Stop. A design that mixed up the two exit sets would leave Wait on CAN activity, or wake from Stop on a clocked interrupt. It counts edges across the synchronizer and samples Stop one edge before the expected exit, which catches an exit that comes too early or too late. It writes a lock and then tries to clear it by rewriting and by an external reset, which exposes a permanent disable that acts like an ordinary register. It also moves the clock select away from the oscillator while the PLL is off. A design that latched the power-down would then keep the PLL off with no oscillator clock.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_STOP = 2'd2
  } lpm_mode_e;

  localparam int unsigned NUM_SLEEP = 2;          // index 0 stop, 1 wait
  localparam int unsigned CFG_W     = 2 * NUM_SLEEP;
  localparam int unsigned SLP_STOP  = 0;
  localparam int unsigned SLP_WAIT  = 1;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         sys_rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       chain[0] <= '0;
    else if (sys_rst) chain[0] <= '0;
    else              chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)       chain[s] <= '0;
      else if (sys_rst) chain[s] <= '0;
      else              chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lpm_dis_pair.sv
module lpm_dis_pair (
  input  logic clk,
  input  logic por_n,
  input  logic sys_rst,
  input  logic wr_en,
  input  logic wr_reprog,
  input  logic wr_lock,
  output logic disabled
);
  logic lock_q, lock_used_q, reprog_q;

  // one-time lock: only power-on reset reaches it
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lock_q      <= 1'b0;
      lock_used_q <= 1'b0;
    end else if (wr_en && !lock_used_q) begin
      lock_q      <= wr_lock;
      lock_used_q <= 1'b1;
    end
  end

  // reprogrammable bit: every reset source clears it
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       reprog_q <= 1'b0;
    else if (sys_rst) reprog_q <= 1'b0;
    else if (wr_en)   reprog_q <= wr_reprog;
  end

  assign disabled = lock_q | reprog_q;
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      por_n,
  input  logic      sys_rst,
  input  logic      stop_go,
  input  logic      wait_go,
  input  logic      irq_pending,
  input  logic      irq_s,
  input  logic      can_s,
  output lpm_mode_e mode_q,
  output logic      drop_q
);
  lpm_mode_e mode_d;
  logic      drop_d;

  always_comb begin
    mode_d = mode_q;
    drop_d = 1'b0;
    unique case (mode_q)
      MODE_RUN: begin
        if (stop_go)      mode_d = MODE_STOP;
        else if (wait_go) mode_d = MODE_WAIT;
      end
      MODE_WAIT: begin
        if (irq_pending || irq_s) mode_d = MODE_RUN;
      end
      MODE_STOP: begin
        if (can_s || irq_s) begin
          mode_d = MODE_RUN;
          drop_d = can_s;
        end
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_q <= MODE_RUN;
      drop_q <= 1'b0;
    end else if (sys_rst) begin
      mode_q <= MODE_RUN;
      drop_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      drop_q <= drop_d;
    end
  end
endmodule

// File: rtl/lpm_clkgate_ctrl.sv
module lpm_clkgate_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             ext_rst_n,
  input  logic             wdog_rst,
  input  logic             wait_req,
  input  logic             stop_req,
  input  logic             irq_pending,
  input  logic             async_irq,
  input  logic             can_wake,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             clk_sel_osc,
  input  logic             pll_pd_req,
  output logic [1:0]       mode,
  output logic             core_clk_en,
  output logic             mem_clk_en,
  output logic             periph_clk_en,
  output logic             wdog_clk_en,
  output logic             pll_pd,
  output logic             can_drop_frame
);
  logic                 sys_rst;
  logic [1:0]           wake_s;
  logic                 can_s, irq_s;
  logic [NUM_SLEEP-1:0] dis;
  logic                 stop_dis, wait_dis;
  lpm_mode_e            mode_q;
  logic                 pll_pd_q;

  assign sys_rst = !ext_rst_n || wdog_rst;

  lpm_sync #(.W(2), .STAGES(SYNC_STAGES)) i_wake_sync (
    .clk     (clk),
    .por_n   (por_n),
    .sys_rst (sys_rst),
    .d       ({can_wake, async_irq}),
    .q       (wake_s)
  );
  assign can_s = wake_s[1];
  assign irq_s = wake_s[0];

  for (genvar i = 0; i < NUM_SLEEP; i++) begin : g_dis
    lpm_dis_pair i_dis (
      .clk       (clk),
      .por_n     (por_n),
      .sys_rst   (sys_rst),
      .wr_en     (cfg_we),
      .wr_reprog (cfg_wdata[i]),
      .wr_lock   (cfg_wdata[i+NUM_SLEEP]),
      .disabled  (dis[i])
    );
  end
  assign stop_dis = dis[SLP_STOP];
  assign wait_dis = dis[SLP_WAIT];

  lpm_mode_fsm i_fsm (
    .clk         (clk),
    .por_n       (por_n),
    .sys_rst     (sys_rst),
    .stop_go     (stop_req && !stop_dis),
    .wait_go     (wait_req && !wait_dis),
    .irq_pending (irq_pending),
    .irq_s       (irq_s),
    .can_s       (can_s),
    .mode_q      (mode_q),
    .drop_q      (can_drop_frame)
  );

  // PLL may be off only while the oscillator drives the system clock
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       pll_pd_q <= 1'b0;
    else if (sys_rst) pll_pd_q <= 1'b0;
    else              pll_pd_q <= pll_pd_req && clk_sel_osc;
  end
  assign pll_pd = pll_pd_q;

  always_comb begin
    core_clk_en   = (mode_q == MODE_RUN);
    mem_clk_en    = (mode_q == MODE_RUN);
    periph_clk_en = (mode_q != MODE_STOP);
  end
  assign wdog_clk_en = 1'b1;
  assign mode        = mode_q;
endmodule

// File: rtl/lpm_clkgate_chk.sv
module lpm_clkgate_chk
  import lpm_pkg::*;
(
  input logic       clk,
  input logic       por_n,
  input logic       sys_rst,
  input logic [1:0] mode,
  input logic       core_clk_en,
  input logic       mem_clk_en,
  input logic       periph_clk_en,
  input logic       irq_pending,
  input logic       irq_s,
  input logic       can_s,
  input logic       stop_dis,
  input logic       wait_dis,
  input logic       clk_sel_osc,
  input logic       pll_pd_req,
  input logic       pll_pd,
  input logic       can_drop_frame
);
  AST_RUN_CLOCKS: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_RUN) |-> (core_clk_en && mem_clk_en && periph_clk_en)); // R1

  AST_WAIT_CLOCKS: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_WAIT) |-> (!core_clk_en && !mem_clk_en && periph_clk_en)); // R2

  AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_WAIT && !sys_rst) |=> ((mode == MODE_RUN) == ($past(irq_pending) || $past(irq_s)))); // R3

  AST_STOP_CLOCKS: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_STOP) |-> (!core_clk_en && !mem_clk_en && !periph_clk_en)); // R4

  AST_STOP_EXIT: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_STOP && !sys_rst) |=> ((mode == MODE_RUN) == ($past(can_s) || $past(irq_s)))); // R5

  AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
    can_drop_frame |-> (mode == MODE_RUN && $past(mode) == MODE_STOP && $past(can_s))); // R6

  AST_STOP_BLOCKED: assert property (@(posedge clk) disable iff (!por_n)
    ($past(mode) == MODE_RUN && mode == MODE_STOP) |-> !$past(stop_dis)); // R9

  AST_WAIT_BLOCKED: assert property (@(posedge clk) disable iff (!por_n)
    ($past(mode) == MODE_RUN && mode == MODE_WAIT) |-> !$past(wait_dis)); // R9

  AST_PLL_OSC_ONLY: assert property (@(posedge clk) disable iff (!por_n)
    pll_pd |-> $past(pll_pd_req && clk_sel_osc)); // R10

  AST_RESET_TO_RUN: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |=> (mode == MODE_RUN && !can_drop_frame)); // R12
endmodule

bind lpm_clkgate_ctrl lpm_clkgate_chk i_chk (
  .clk            (clk),
  .por_n          (por_n),
  .sys_rst        (sys_rst),
  .mode           (mode),
  .core_clk_en    (core_clk_en),
  .mem_clk_en     (mem_clk_en),
  .periph_clk_en  (periph_clk_en),
  .irq_pending    (irq_pending),
  .irq_s          (irq_s),
  .can_s          (can_s),
  .stop_dis       (stop_dis),
  .wait_dis       (wait_dis),
  .clk_sel_osc    (clk_sel_osc),
  .pll_pd_req     (pll_pd_req),
  .pll_pd         (pll_pd),
  .can_drop_frame (can_drop_frame)
);

// File: tb/test_lpm_clkgate_ctrl.sv
`timescale 1ns/1ps
module test_lpm_clkgate_ctrl;
  logic       clk = 1'b0;
  logic       por_n = 1'b0, ext_rst_n = 1'b1, wdog_rst = 1'b0;
  logic       wait_req = 1'b0, stop_req = 1'b0, irq_pending = 1'b0;
  logic       async_irq = 1'b0, can_wake = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_wdata = 4'd0;
  logic       clk_sel_osc = 1'b0, pll_pd_req = 1'b0;
  logic [1:0] mode;
  logic       core_clk_en, mem_clk_en, periph_clk_en, wdog_clk_en, pll_pd, can_drop_frame;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  lpm_clkgate_ctrl i_lpm_clkgate_ctrl (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdog_rst(wdog_rst),
    .wait_req(wait_req), .stop_req(stop_req), .irq_pending(irq_pending),
    .async_irq(async_irq), .can_wake(can_wake), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .clk_sel_osc(clk_sel_osc), .pll_pd_req(pll_pd_req),
    .mode(mode), .core_clk_en(core_clk_en), .mem_clk_en(mem_clk_en),
    .periph_clk_en(periph_clk_en), .wdog_clk_en(wdog_clk_en), .pll_pd(pll_pd),
    .can_drop_frame(can_drop_frame)
  );

  // {cfg reprog [1:0], wait_req, stop_req, expected mode [1:0]}
  localparam logic [5:0] VEC [8] = '{
    {2'b00, 1'b1, 1'b0, 2'd1},
    {2'b00, 1'b0, 1'b1, 2'd2},
    {2'b00, 1'b1, 1'b1, 2'd2},
    {2'b01, 1'b1, 1'b1, 2'd1},
    {2'b01, 1'b0, 1'b1, 2'd0},
    {2'b10, 1'b1, 1'b0, 2'd0},
    {2'b10, 1'b0, 1'b1, 2'd2},
    {2'b11, 1'b1, 1'b1, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_clocks(input string tag, input logic [1:0] m);
    chk(tag, {29'd0, core_clk_en, mem_clk_en, periph_clk_en},
        (m == 2'd0) ? 32'd7 : (m == 2'd1) ? 32'd1 : 32'd0);
    chk(tag, {31'd0, wdog_clk_en}, 32'd1);
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_por();
    @(negedge clk) por_n = 1'b0;
    @(negedge clk) por_n = 1'b1;
  endtask

  task automatic do_rst();
    @(negedge clk) ext_rst_n = 1'b0;
    @(negedge clk) ext_rst_n = 1'b1;
  endtask

  task automatic do_cfg(input logic [3:0] d);
    @(negedge clk) begin cfg_we = 1'b1; cfg_wdata = d; end
    @(negedge clk) begin cfg_we = 1'b0; cfg_wdata = 4'd0; end
  endtask

  task automatic do_req(input logic w, input logic s);
    @(negedge clk) begin wait_req = w; stop_req = s; end
    @(negedge clk) begin wait_req = 1'b0; stop_req = 1'b0; end
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    // R1: reset state while por_n held and after release
    chk("R1 mode in por", {30'd0, mode}, 32'd0);
    por_n = 1'b1;
    tick(1);
    chk("R1 mode", {30'd0, mode}, 32'd0);
    chk_clocks("R1 clocks", 2'd0);
    chk("R1 pll_pd", {31'd0, pll_pd}, 32'd0);
    chk("R1 drop", {31'd0, can_drop_frame}, 32'd0);

    // vector walk: R2 R4 R7 R9 R11
    for (int v = 0; v < 8; v++) begin
      do_rst();
      do_cfg({2'b00, VEC[v][5:4]});
      do_req(VEC[v][3], VEC[v][2]);
      chk($sformatf("R9 vec%0d mode", v), {30'd0, mode}, {30'd0, VEC[v][1:0]});
      chk_clocks($sformatf("R2 R4 R11 vec%0d clocks", v), VEC[v][1:0]);
    end

    // R3: irq_pending ends wait at next edge
    do_rst();
    do_req(1'b1, 1'b0);
    chk("R2 enter wait", {30'd0, mode}, 32'd1);
    @(negedge clk) irq_pending = 1'b1;
    @(negedge clk) irq_pending = 1'b0;
    chk("R3 irq wakes wait", {30'd0, mode}, 32'd0);

    // R3: can_wake ignored in wait; async_irq wakes after 3 edges
    do_req(1'b1, 1'b0);
    @(negedge clk) can_wake = 1'b1;
    tick(5);
    chk("R3 can ignored in wait", {30'd0, mode}, 32'd1);
    chk("R3 no drop in wait", {31'd0, can_drop_frame}, 32'd0);
    can_wake = 1'b0;
    tick(3);
    @(negedge clk) async_irq = 1'b1;
    tick(3);
    chk("R3 async irq wakes wait", {30'd0, mode}, 32'd0);
    async_irq = 1'b0;
    tick(3);

    // R5: irq_pending ignored in stop
    do_req(1'b0, 1'b1);
    @(negedge clk) irq_pending = 1'b1;
    tick(5);
    chk("R5 clocked irq ignored", {30'd0, mode}, 32'd2);
    irq_pending = 1'b0;

    // R5 R6: can wake timing and drop pulse
    @(negedge clk) can_wake = 1'b1;
    tick(2);
    chk("R5 still stop before sync", {30'd0, mode}, 32'd2);
    tick(1);
    chk("R5 can wakes stop", {30'd0, mode}, 32'd0);
    chk("R6 drop pulse", {31'd0, can_drop_frame}, 32'd1);
    can_wake = 1'b0;
    tick(1);
    chk("R6 drop one cycle", {31'd0, can_drop_frame}, 32'd0);
    tick(3);

    // R5 R6: async irq wakes stop, no drop
    do_req(1'b0, 1'b1);
    @(negedge clk) async_irq = 1'b1;
    tick(2);
    chk("R5 irq still stop", {30'd0, mode}, 32'd2);
    tick(1);
    chk("R5 async irq wakes stop", {30'd0, mode}, 32'd0);
    chk("R6 no drop on irq", {31'd0, can_drop_frame}, 32'd0);
    async_irq = 1'b0;
    tick(3);

    // R12: watchdog reset from stop
    do_req(1'b0, 1'b1);
    @(negedge clk) wdog_rst = 1'b1;
    @(negedge clk) wdog_rst = 1'b0;
    chk("R12 wdog reset to run", {30'd0, mode}, 32'd0);
    chk_clocks("R12 clocks", 2'd0);

    // R12: por is immediate
    do_req(1'b1, 1'b0);
    #1 por_n = 1'b0;
    #0.5;
    chk("R12 por async", {30'd0, mode}, 32'd0);
    @(negedge clk) por_n = 1'b1;

    // R7: reprogrammable disable cleared by reset
    do_cfg(4'b0001);
    do_req(1'b0, 1'b1);
    chk("R7 reprog blocks stop", {30'd0, mode}, 32'd0);
    do_rst();
    do_req(1'b0, 1'b1);
    chk("R7 reset clears reprog", {30'd0, mode}, 32'd2);
    do_rst();

    // R8: permanent lock
    do_por();
    do_cfg(4'b0100);
    do_req(1'b0, 1'b1);
    chk("R8 lock blocks stop", {30'd0, mode}, 32'd0);
    do_cfg(4'b0000);
    do_req(1'b0, 1'b1);
    chk("R8 lock ignores rewrite", {30'd0, mode}, 32'd0);
    do_rst();
    do_req(1'b0, 1'b1);
    chk("R8 lock survives reset", {30'd0, mode}, 32'd0);
    do_req(1'b1, 1'b1);
    chk("R9 blocked stop falls to wait", {30'd0, mode}, 32'd1);
    do_rst();
    do_por();
    do_req(1'b0, 1'b1);
    chk("R8 por clears lock", {30'd0, mode}, 32'd2);
    do_rst();

    // R8: first write with zero lock, later lock write ignored
    do_por();
    do_cfg(4'b0000);
    do_cfg(4'b1000);
    do_req(1'b1, 1'b0);
    chk("R8 late lock write ignored", {30'd0, mode}, 32'd1);
    do_rst();

    // R10: pll power-down tied to oscillator select
    @(negedge clk) begin pll_pd_req = 1'b1; clk_sel_osc = 1'b0; end
    tick(2);
    chk("R10 refused without osc", {31'd0, pll_pd}, 32'd0);
    @(negedge clk) clk_sel_osc = 1'b1;
    @(negedge clk);
    chk("R10 accepted on osc", {31'd0, pll_pd}, 32'd1);
    do_req(1'b0, 1'b1);
    chk("R10 stop keeps pll", {31'd0, pll_pd}, 32'd1);
    do_rst();
    @(negedge clk) pll_pd_req = 1'b0;
    @(negedge clk);
    chk("R10 released", {31'd0, pll_pd}, 32'd0);
    tick(1);
    chk("R10 stop leaves pll on", {31'd0, pll_pd}, 32'd0);
    @(negedge clk) pll_pd_req = 1'b1;
    @(negedge clk) clk_sel_osc = 1'b0;
    @(negedge clk);
    chk("R10 select away powers up", {31'd0, pll_pd}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule